// File: doc/BRIEF.md
# Temperature-Driven Calibration Table Selector

This block watches a stream of internal temperature readings and decides which calibration table the timing datapath should use. There is one table for every whole degree Celsius between a lower and an upper limit. The limits are inputs to the block. The block remembers the nominal temperature of the table that is currently in force. It asks for a different table only when a reading drifts more than half a degree away from that nominal value.

When a different table is needed, the block emits a one-cycle request that carries the wanted table index, then waits. While it waits it reports busy. The host swaps the table contents and answers with a load acknowledge, and only then does the active index move.

Readings that arrive while a request is outstanding are parked. Only the most recent parked reading is judged once the acknowledge has come back. Readings outside the calibrated range select the nearest end table. After reset no table is active, so the first reading always produces a request.

Top module: `cal_table_selector`

## Requirements
- R1: After reset `active_valid`, `busy` and `change_req` are all low.
- R2: While no table is active, every evaluated reading issues a request, whatever its value.
- R3: `temp_sample` is signed two's complement with 2 fractional bits (1 LSB = 0.25 °C). The requested index is the reading rounded to the nearest whole degree, with a tie of exactly x.5 rounding towards plus infinity.
- R4: A rounded reading below `t_min` requests index `t_min`, and one above `t_max` requests index `t_max`. Indices are signed whole degrees.
- R5: With a table active, a reading whose distance from the active index is at most 0.5 °C (2 LSBs) produces no request. A larger distance produces a request.
- R6: No request is issued when the clamped target equals the active index, even if the reading lies far outside the range.
- R7: `change_req` is high for exactly one cycle, with `req_idx` valid in that cycle. `busy` rises in the same cycle and stays high until `table_loaded` is seen.
- R8: `active_idx` and `active_valid` change only on `table_loaded` while busy; they then take the requested index. `table_loaded` while idle has no effect.
- R9: Readings taken while busy never raise a request. After the acknowledge, only the newest of them is evaluated, and any request from it appears two cycles after the `table_loaded` cycle.
- R10: A reading accepted while idle yields its request on the clock edge that registers it, so `change_req` is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_valid | input | 1 | Strobe for a new temperature reading |
| temp_sample | input | TEMP_W | Signed reading, 2 fractional bits |
| t_min | input | IDX_W | Lowest calibrated whole degree (signed) |
| t_max | input | IDX_W | Highest calibrated whole degree (signed) |
| table_loaded | input | 1 | Host acknowledge that the requested table is in place |
| active_idx | output | IDX_W | Index of the table in force |
| active_valid | output | 1 | A table is in force |
| change_req | output | 1 | One-cycle request for a new table |
| req_idx | output | IDX_W | Index carried by the request |
| busy | output | 1 | A request awaits its acknowledge |

## Verification
The hardest situation to reach from the ports is a reading parked while a request is outstanding. Its evaluation must use the freshly loaded index rather than the one in force when it arrived. The stimulus raises a request, feeds several readings before acknowledging, and arranges the newest one in two ways. In one it sits inside the half-degree band of the new table, so no request must follow. In the other it lies outside that band, so a request for its own index must follow. Hysteresis and clamping are covered by walking every quarter-degree reading beyond both range limits against every possible active table.

// File: rtl/calsel_pkg.sv
package calsel_pkg;
    // fractional bits of the temperature reading
    localparam int FRAC = 2;
    // half a degree expressed in reading LSBs
    localparam int HALF_LSB = 1 << (FRAC - 1);
endpackage

// File: rtl/cal_round_clamp.sv
module cal_round_clamp
    import calsel_pkg::*;
#(
    parameter int TEMP_W = 10,
    parameter int IDX_W  = 8
) (
    input  logic signed [TEMP_W-1:0] temp,
    input  logic signed [IDX_W-1:0]  lo,
    input  logic signed [IDX_W-1:0]  hi,
    output logic signed [IDX_W-1:0]  target
);
    localparam int RW = TEMP_W + 1;

    logic signed [RW-1:0] t_ext, rnd, lo_ext, hi_ext, clamped;

    always_comb begin
        t_ext   = {temp[TEMP_W-1], temp};
        rnd     = (t_ext + RW'(HALF_LSB)) >>> FRAC;
        lo_ext  = {{(RW-IDX_W){lo[IDX_W-1]}}, lo};
        hi_ext  = {{(RW-IDX_W){hi[IDX_W-1]}}, hi};
        if (rnd < lo_ext)      clamped = lo_ext;
        else if (rnd > hi_ext) clamped = hi_ext;
        else                   clamped = rnd;
        target  = IDX_W'(clamped);
    end

    // R4
    always_comb begin
        if (lo <= hi)
            in_range_chk: assert (target >= lo && target <= hi);
    end
endmodule

// File: rtl/cal_drift_check.sv
module cal_drift_check
    import calsel_pkg::*;
#(
    parameter int TEMP_W = 10,
    parameter int IDX_W  = 8
) (
    input  logic signed [TEMP_W-1:0] temp,
    input  logic signed [IDX_W-1:0]  act_idx,
    input  logic                     act_valid,
    input  logic signed [IDX_W-1:0]  target,
    output logic                     need_switch
);
    localparam int DW = TEMP_W + IDX_W + 2;

    logic signed [DW-1:0] t_ext, a_ext, diff, mag;

    always_comb begin
        t_ext = {{(DW-TEMP_W){temp[TEMP_W-1]}}, temp};
        a_ext = {{(DW-IDX_W){act_idx[IDX_W-1]}}, act_idx} <<< FRAC;
        diff  = t_ext - a_ext;
        mag   = (diff < 0) ? -diff : diff;
        need_switch = !act_valid || ((mag > DW'(HALF_LSB)) && (target != act_idx));
    end
endmodule

// File: rtl/cal_table_selector.sv
module cal_table_selector
    import calsel_pkg::*;
#(
    parameter int TEMP_W = 10,
    parameter int IDX_W  = TEMP_W - FRAC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     temp_valid,
    input  logic signed [TEMP_W-1:0] temp_sample,
    input  logic signed [IDX_W-1:0]  t_min,
    input  logic signed [IDX_W-1:0]  t_max,
    input  logic                     table_loaded,
    output logic signed [IDX_W-1:0]  active_idx,
    output logic                     active_valid,
    output logic                     change_req,
    output logic signed [IDX_W-1:0]  req_idx,
    output logic                     busy
);
    typedef struct packed {
        logic                     act_valid;
        logic signed [IDX_W-1:0]  act_idx;
        logic                     busy;
        logic                     req;
        logic signed [IDX_W-1:0]  req_idx;
        logic                     pend;
        logic signed [TEMP_W-1:0] pend_temp;
    } state_t;

    state_t st_q, st_d;

    logic                     eval_en;
    logic signed [TEMP_W-1:0] eval_temp;
    logic signed [IDX_W-1:0]  tgt;
    logic                     need;

    assign eval_en   = !st_q.busy && (temp_valid || st_q.pend);
    assign eval_temp = temp_valid ? temp_sample : st_q.pend_temp;

    cal_round_clamp #(.TEMP_W(TEMP_W), .IDX_W(IDX_W)) u_round (
        .temp   (eval_temp),
        .lo     (t_min),
        .hi     (t_max),
        .target (tgt)
    );

    cal_drift_check #(.TEMP_W(TEMP_W), .IDX_W(IDX_W)) u_drift (
        .temp        (eval_temp),
        .act_idx     (st_q.act_idx),
        .act_valid   (st_q.act_valid),
        .target      (tgt),
        .need_switch (need)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (st_q.busy) begin
            if (temp_valid) begin
                st_d.pend      = 1'b1;
                st_d.pend_temp = temp_sample;
            end
            if (table_loaded) begin
                st_d.busy      = 1'b0;
                st_d.act_valid = 1'b1;
                st_d.act_idx   = st_q.req_idx;
            end
        end else if (eval_en) begin
            st_d.pend = 1'b0;
            if (need) begin
                st_d.req     = 1'b1;
                st_d.busy    = 1'b1;
                st_d.req_idx = tgt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_idx   = st_q.act_idx;
    assign active_valid = st_q.act_valid;
    assign change_req   = st_q.req;
    assign req_idx      = st_q.req_idx;
    assign busy         = st_q.busy;

    // R7
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        change_req |=> !change_req);

    // R7
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        change_req |-> busy && $past(!busy));

    // R8
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(active_idx) || $rose(active_valid)) |-> $past(table_loaded && busy));

    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(table_loaded));

    // R4
    req_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (change_req && $stable(t_min) && $stable(t_max) && t_min <= t_max)
        |-> (req_idx >= t_min && req_idx <= t_max));
endmodule

// File: tb/cal_table_selector_bench.sv
module cal_table_selector_bench;
    localparam int TEMP_W = 10;
    localparam int IDX_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic temp_valid = 1'b0;
    logic signed [TEMP_W-1:0] temp_sample = '0;
    logic signed [IDX_W-1:0]  t_min = -8'sd3;
    logic signed [IDX_W-1:0]  t_max = 8'sd5;
    logic table_loaded = 1'b0;
    logic signed [IDX_W-1:0]  active_idx, req_idx;
    logic active_valid, change_req, busy;

    int n_run = 0;
    int n_fail = 0;
    int exp_act = 0;
    bit exp_valid = 0;

    always #5 clk = ~clk;

    cal_table_selector #(.TEMP_W(TEMP_W), .IDX_W(IDX_W)) u_cal_table_selector (
        .clk, .rst_n, .temp_valid, .temp_sample, .t_min, .t_max, .table_loaded,
        .active_idx, .active_valid, .change_req, .req_idx, .busy
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int target_of(int t);
        int r = (t + 2) >>> 2;
        if (r < int'(t_min)) r = int'(t_min);
        if (r > int'(t_max)) r = int'(t_max);
        return r;
    endfunction

    function automatic bit need_of(int t);
        int d = t - 4 * exp_act;
        if (d < 0) d = -d;
        return !exp_valid || (d > 2 && target_of(t) != exp_act);
    endfunction

    task automatic load();
        table_loaded = 1'b1;
        @(negedge clk);
        table_loaded = 1'b0;
    endtask

    // one reading from idle, with the full request/acknowledge cycle when due
    task automatic send(int t);
        int  tg  = target_of(t);
        bit  rq  = need_of(t);
        int  raw = (t + 2) >>> 2;
        string tag = !exp_valid ? "R2" :
                     (raw < int'(t_min) || raw > int'(t_max)) ? "R6" : "R5";
        @(negedge clk);
        temp_valid  = 1'b1;
        temp_sample = TEMP_W'(t);
        @(negedge clk);
        temp_valid  = 1'b0;
        chk(change_req == rq, tag, int'(change_req), int'(rq));
        if (rq) begin
            chk(req_idx == IDX_W'(tg), (raw == tg) ? "R3" : "R4", int'(req_idx), tg);
            chk(busy == 1'b1, "R7", int'(busy), 1);
            @(negedge clk);
            chk(change_req == 1'b0, "R7", int'(change_req), 0);
            chk(active_valid == exp_valid && (!exp_valid || active_idx == IDX_W'(exp_act)),
                "R8", int'(active_idx), exp_act);
            load();
            exp_act = tg;
            exp_valid = 1;
            chk(active_idx == IDX_W'(tg) && active_valid, "R8", int'(active_idx), tg);
            chk(busy == 1'b0, "R7", int'(busy), 0);
        end
    endtask

    task automatic sweep(int lo, int hi);
        t_min = IDX_W'(lo);
        t_max = IDX_W'(hi);
        for (int a = lo; a <= hi; a++) begin
            for (int t = 4 * lo - 12; t <= 4 * hi + 12; t++) begin
                send(4 * a);
                send(t);
            end
        end
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(!active_valid && !busy && !change_req, "R1", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: acknowledge while idle is ignored
        load();
        chk(active_valid == 1'b0, "R8", int'(active_valid), 0);

        // R2 first reading far outside range still requests, clamped
        send(-60);
        sweep(-3, 5);

        // R8: idle acknowledge does not move the active table
        load();
        @(negedge clk);
        chk(active_idx == IDX_W'(exp_act), "R8", int'(active_idx), exp_act);

        // R9: parked readings, newest inside band of new table
        send(0);
        @(negedge clk); temp_valid = 1'b1; temp_sample = 10'sd12;
        @(negedge clk); temp_valid = 1'b0;
        chk(change_req && req_idx == 8'sd3, "R10", int'(req_idx), 3);
        temp_valid = 1'b1; temp_sample = 10'sd20;
        @(negedge clk); temp_sample = 10'sd13;
        @(negedge clk); temp_valid = 1'b0;
        chk(change_req == 1'b0, "R9", int'(change_req), 0);
        load();
        chk(active_idx == 8'sd3, "R8", int'(active_idx), 3);
        @(negedge clk);
        chk(change_req == 1'b0, "R9", int'(change_req), 0);
        exp_act = 3;

        // R9: newest parked reading lies outside band
        @(negedge clk); temp_valid = 1'b1; temp_sample = 10'sd0;
        @(negedge clk); temp_valid = 1'b0;
        chk(change_req && req_idx == 8'sd0, "R10", int'(req_idx), 0);
        temp_valid = 1'b1; temp_sample = 10'sd13;
        @(negedge clk); temp_sample = 10'sd20;
        @(negedge clk); temp_valid = 1'b0;
        chk(change_req == 1'b0, "R9", int'(change_req), 0);
        load();
        chk(change_req == 1'b0 && active_idx == 8'sd0, "R9", int'(active_idx), 0);
        @(negedge clk);
        chk(change_req && req_idx == 8'sd5, "R9", int'(req_idx), 5);
        @(negedge clk);
        load();
        exp_act = 5;
        chk(active_idx == 8'sd5 && !busy, "R8", int'(active_idx), 5);

        // second range, offset from zero
        sweep(10, 12);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule